// File: doc/BRIEF.md
# Three-Channel Centred Complementary PWM Generator

This block drives three PWM channels from one shared switching period. Each channel has its own signed duty setting and a pair of complementary outputs: a high-side pin and a low-side pin. Every pulse is placed symmetrically in the middle of the period. A shared dead-time setting shortens both pins of every channel, which opens a guard gap around each edge. A per-channel crossover bit exchanges the two pins. The high-side pin can then reach duty ratios below one half. One typical use is as a coarse digital-to-analog output: a control loop or table writer updates the duty once per period and an external low-pass filter smooths the pin.

Software writes every setting through a single-cycle write port into shadow registers. A shadow register has no effect on the outputs until the end of the running period. At that boundary all shadow values move into the active set together, and the block outputs a one-cycle `sync_o` pulse. The writer should load the values for the following period after that pulse. With a period setting P, one switching period lasts 2·P clock cycles. The high-side pin is on for P + 2(D − T) cycles and the low-side pin for P − 2(D + T) cycles, where D is the duty and T the dead time.

Top module: `cpwm_core`

## Requirements
- R1: `sync_o` is high for exactly one cycle in each switching period, and two consecutive pulses are 2·P cycles apart. The output cycle that carries a pulse is the final cycle of its period. A period setting of 0x1000 gives 0x2000 cycles.
- R2: When P + 2(D − T) lies within 0..2P, a channel's high-side pin is high for exactly that many cycles of the period. D is two's complement and T is unsigned.
- R3: When P − 2(D + T) lies within 0..2P, a channel's low-side pin is high for exactly that many cycles of the period.
- R4: A high-side pulse of W cycles starts at phase P − floor(W/2). Phase 0 is the first output cycle after a cycle that carries `sync_o`, so the pulse sits in the middle of the period.
- R5: The high-side and low-side pins of one channel are never high in the same cycle.
- R6: An on-time that computes below 0 holds the pin low for the whole period. An on-time that computes above 2P holds it high for the whole period. No value wraps.
- R7: A write changes only the shadow copy. The active settings stay constant between `sync_o` pulses. A write made during a period first acts in the period that starts after the next `sync_o`.
- R8: When crossover bit i is set, channel i's high-side pin carries the low-side waveform and its low-side pin carries the high-side waveform.
- R9: While `en` is low, all pins and `sync_o` are low from the next cycle onward. Writes made while disabled are in effect one cycle later. When `en` rises, a full period begins with the first enabled cycle, and its first output sample appears one cycle later.
- R10: With an active period of 0, `sync_o` is high in every enabled cycle and all pins stay low. A write therefore takes effect on the following cycle.
- R11: The write address map is as follows. Address 0 is the period (unsigned). Address 1 is the dead time (unsigned). Address 2 is the crossover bits, where bit i selects channel i. Address 3+i is the duty of channel i (two's complement). Addresses 6 and 7 change nothing.
- R12: Reset clears all shadow and active registers and drives every pin and `sync_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces pins low and restarts the period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 3 | High-side pin of each channel |
| pwm_lo | output | 3 | Low-side pin of each channel |
| sync_o | output | 1 | One-cycle pulse on the last cycle of each period |

## Verification
On every cycle the assertions check four things: the two pins of a channel never overlap, a disabled block stays silent, the active settings never move between sync pulses, and consecutive sync pulses sit exactly twice the latched period apart. They also check that a zero period gives a pulse every cycle with quiet pins. The exact on-time counts, the start phase of each centred pulse, the clamping, the crossover swap, the address decoding and the one-period delay of a mid-period write all depend on arithmetic over whole periods. Only the bench's sweeps over small periods, duties and dead times can show those, together with one run at a period of 0x1000.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Block configuration
    localparam int unsigned PERIOD_W = 16;
    localparam int unsigned NUM_CH   = 3;

    // Derived widths
    localparam int unsigned PHASE_W  = PERIOD_W + 1;   // 0 .. 2P-1
    localparam int unsigned SPAN_W   = PERIOD_W + 3;   // doubled phase plus on-time
    localparam int unsigned CALC_W   = PERIOD_W + 4;   // signed on-time arithmetic
    localparam int unsigned DUTY_BASE = 3;
    localparam int unsigned ADDR_W   = $clog2(DUTY_BASE + NUM_CH);

    // Write address map
    localparam logic [ADDR_W-1:0] ADR_PERIOD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_DEAD   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_XOVER  = ADDR_W'(2);

    typedef logic        [PERIOD_W-1:0] period_t;
    typedef logic signed [PERIOD_W-1:0] duty_t;
    typedef logic        [PHASE_W-1:0]  phase_t;
    typedef logic        [SPAN_W-1:0]   span_t;
    typedef logic signed [CALC_W-1:0]   calc_t;

    // One complete register set (shadow or active)
    typedef struct packed {
        period_t                   period;
        period_t                   dead;
        logic [NUM_CH-1:0]         xover;
        duty_t [NUM_CH-1:0]        duty;
    } cfg_t;

    // Drive pair of one channel
    typedef struct packed {
        logic hi;
        logic lo;
    } drive_t;

    // Raw high-side on-time: P + 2(D - T)
    function automatic calc_t hi_raw(input period_t p, input duty_t d, input period_t t);
        calc_t ps, ds, ts;
        ps = $signed({{(CALC_W-PERIOD_W){1'b0}}, p});
        ds = $signed({{(CALC_W-PERIOD_W){d[PERIOD_W-1]}}, d});
        ts = $signed({{(CALC_W-PERIOD_W){1'b0}}, t});
        return ps + ((ds - ts) <<< 1);
    endfunction

    // Raw low-side on-time: P - 2(D + T)
    function automatic calc_t lo_raw(input period_t p, input duty_t d, input period_t t);
        calc_t ps, ds, ts;
        ps = $signed({{(CALC_W-PERIOD_W){1'b0}}, p});
        ds = $signed({{(CALC_W-PERIOD_W){d[PERIOD_W-1]}}, d});
        ts = $signed({{(CALC_W-PERIOD_W){1'b0}}, t});
        return ps - ((ds + ts) <<< 1);
    endfunction

    // Saturate an on-time into 0 .. 2P
    function automatic span_t clamp_on(input calc_t v, input period_t p);
        calc_t lim;
        lim = $signed({{(CALC_W-PERIOD_W-1){1'b0}}, p, 1'b0});
        if (v < 0)
            return '0;
        else if (v > lim)
            return lim[SPAN_W-1:0];
        else
            return v[SPAN_W-1:0];
    endfunction

    // True when phase lies in a window of w cycles centred on phase P:
    // 2P - w <= 2*ph < 2P + w
    function automatic logic in_window(input phase_t ph, input period_t p, input span_t w);
        span_t ph2, p2;
        ph2 = {1'b0, ph, 1'b0};
        p2  = {2'b00, p, 1'b0};
        return ((ph2 + w) >= p2) && (ph2 < (p2 + w));
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PERIOD_W-1:0] wr_data,
    input  logic                commit,
    output cfg_t                active
);

    cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr_en) begin
                if (wr_addr == ADR_PERIOD) shadow.period <= wr_data;
                if (wr_addr == ADR_DEAD)   shadow.dead   <= wr_data;
                if (wr_addr == ADR_XOVER)  shadow.xover  <= wr_data[NUM_CH-1:0];
                for (int i = 0; i < NUM_CH; i++) begin
                    if (wr_addr == ADDR_W'(DUTY_BASE + i))
                        shadow.duty[i] <= wr_data;
                end
            end
            // The shadow copy moves as a whole; a write on the same edge
            // lands in the shadow and waits for the next boundary.
            if (commit)
                active <= shadow;
        end
    end

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  period_t period,
    output phase_t  phase,
    output logic    wrap
);

    phase_t last;

    assign last = {period, 1'b0} - 1'b1;
    assign wrap = en && ((period == '0) || (phase == last));

    always_ff @(posedge clk) begin
        if (rst || !en)
            phase <= '0;
        else if (wrap)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

endmodule

// File: rtl/cpwm_chan.sv
module cpwm_chan
    import cpwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  phase_t  phase,
    input  period_t period,
    input  period_t dead,
    input  duty_t   duty,
    input  logic    xover,
    output logic    hi_o,
    output logic    lo_o
);

    span_t  w_hi, w_lo, full, gap_lo;
    drive_t raw, pin;

    always_comb begin
        full   = {2'b00, period, 1'b0};
        w_hi   = clamp_on(hi_raw(period, duty, dead), period);
        w_lo   = clamp_on(lo_raw(period, duty, dead), period);
        // Low side is on outside a centred window of 2P - w_lo cycles
        gap_lo = full - w_lo;
        raw.hi = in_window(phase, period, w_hi);
        raw.lo = (period != '0) && !in_window(phase, period, gap_lo);
        if (xover) begin
            pin.hi = raw.lo;
            pin.lo = raw.hi;
        end else begin
            pin = raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hi_o <= 1'b0;
            lo_o <= 1'b0;
        end else begin
            hi_o <= pin.hi;
            lo_o <= pin.lo;
        end
    end

endmodule

// File: rtl/cpwm_core.sv
module cpwm_core
    import cpwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PERIOD_W-1:0] wr_data,
    output logic [NUM_CH-1:0]   pwm_hi,
    output logic [NUM_CH-1:0]   pwm_lo,
    output logic                sync_o
);

    cfg_t   act_cfg;
    phase_t phase;
    logic   wrap;
    logic   commit;

    // Disabled: settings pass straight through; running: only at the boundary
    assign commit = wrap | ~en;

    cpwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .active  (act_cfg)
    );

    cpwm_timebase u_time (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .period (act_cfg.period),
        .phase  (phase),
        .wrap   (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sync_o <= 1'b0;
        else
            sync_o <= wrap;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cpwm_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .phase  (phase),
            .period (act_cfg.period),
            .dead   (act_cfg.dead),
            .duty   (act_cfg.duty[g]),
            .xover  (act_cfg.xover[g]),
            .hi_o   (pwm_hi[g]),
            .lo_o   (pwm_lo[g])
        );
    end

endmodule

// File: rtl/cpwm_core_chk.sv
module cpwm_core_chk
    import cpwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [NUM_CH-1:0] pwm_hi,
    input logic [NUM_CH-1:0] pwm_lo,
    input logic              sync_o,
    input cfg_t              act_cfg
);

    logic               armed;
    logic [PHASE_W:0]   gap;
    period_t            run_p;

    // Cycles since the last sync pulse and the period latched at it
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            armed <= 1'b0;
            gap   <= '0;
            run_p <= '0;
        end else if (sync_o) begin
            armed <= 1'b1;
            gap   <= '0;
            run_p <= act_cfg.period;
        end else begin
            gap   <= gap + 1'b1;
        end
    end

    // R5: complementary pins never overlap
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (pwm_hi & pwm_lo) == '0);

    // R9: disabled block is silent from the next cycle
    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pwm_hi == '0 && pwm_lo == '0 && !sync_o));

    // R1: sync pulses are spaced by twice the period in effect
    a_r1_sync_spacing: assert property (@(posedge clk) disable iff (rst)
        (armed && sync_o && run_p != '0) |-> ((gap + 1'b1) == {run_p, 1'b0}));

    // R7: active settings only move at a sync pulse while running
    a_r7_hold_between_syncs: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $past(!rst) && !sync_o) |-> $stable(act_cfg));

    // R10: zero period pulses sync every cycle with quiet pins
    a_r10_zero_period: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en) && $past(act_cfg.period) == '0)
            |-> (sync_o && pwm_hi == '0 && pwm_lo == '0));

endmodule

bind cpwm_core cpwm_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .pwm_hi  (pwm_hi),
    .pwm_lo  (pwm_lo),
    .sync_o  (sync_o),
    .act_cfg (act_cfg)
);

// File: tb/cpwm_core_tb.sv
module cpwm_core_tb;
    import cpwm_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                en  = 1'b0;
    logic                wr_en = 1'b0;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic [PERIOD_W-1:0] wr_data = '0;
    logic [NUM_CH-1:0]   pwm_hi, pwm_lo;
    logic                sync_o;

    int n_run  = 0;
    int n_fail = 0;

    int m_len, m_ovl;
    int m_hi [NUM_CH];
    int m_lo [NUM_CH];
    int m_hf [NUM_CH];

    cpwm_core u_dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_hi  (pwm_hi),
        .pwm_lo  (pwm_lo),
        .sync_o  (sync_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int p);
        if (v < 0) return 0;
        if (v > 2 * p) return 2 * p;
        return v;
    endfunction

    // Called at a falling edge; returns at a falling edge
    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = PERIOD_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync_o);
    endtask

    // Samples one period, phase 0 first; ends on the cycle carrying sync_o
    task automatic measure(input bit mid_wr, input int a, input int d);
        m_len = 0;
        m_ovl = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            m_hi[c] = 0; m_lo[c] = 0; m_hf[c] = -1;
        end
        forever begin
            @(negedge clk);
            wr_en = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (pwm_hi[c]) begin
                    if (m_hf[c] < 0) m_hf[c] = m_len;
                    m_hi[c]++;
                end
                if (pwm_lo[c]) m_lo[c]++;
                if (pwm_hi[c] && pwm_lo[c]) m_ovl++;
            end
            if (mid_wr && m_len == 2) begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(a);
                wr_data = PERIOD_W'(d);
            end
            m_len++;
            if (sync_o || m_len > 70000) break;
        end
    endtask

    task automatic apply(input int p, input int t, input int x,
                         input int d0, input int d1, input int d2);
        wr(0, p);
        wr(1, t);
        wr(2, x);
        wr(3, d0);
        wr(4, d1);
        wr(5, d2);
        wait_sync();
        wait_sync();
    endtask

    task automatic verify(input int p, input int t, input int x,
                          input int d0, input int d1, input int d2, input string tag);
        int d [NUM_CH];
        int rh, rl, eh, el;
        string sh, sl;
        d[0] = d0; d[1] = d1; d[2] = d2;
        chk(m_len == 2 * p, "R1", {tag, " period length"}, m_len, 2 * p);
        for (int c = 0; c < NUM_CH; c++) begin
            rh = p + 2 * (d[c] - t);
            rl = p - 2 * (d[c] + t);
            eh = clampi(rh, p);
            el = clampi(rl, p);
            sh = (rh < 0 || rh > 2 * p) ? "R6" : "R2";
            sl = (rl < 0 || rl > 2 * p) ? "R6" : "R3";
            if (x[c]) begin
                chk(m_hi[c] == el, "R8", {tag, " swapped high pin"}, m_hi[c], el);
                chk(m_lo[c] == eh, "R8", {tag, " swapped low pin"}, m_lo[c], eh);
            end else begin
                chk(m_hi[c] == eh, sh, {tag, " high-side count"}, m_hi[c], eh);
                chk(m_lo[c] == el, sl, {tag, " low-side count"}, m_lo[c], el);
                if (eh > 0)
                    chk(m_hf[c] == p - eh / 2, "R4", {tag, " pulse start"}, m_hf[c], p - eh / 2);
            end
        end
        chk(m_ovl == 0, "R5", {tag, " overlap cycles"}, m_ovl, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int plist [6];
        int tlist [4];
        plist = '{1, 2, 3, 4, 7, 10};
        tlist = '{0, 1, 3, 9};

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(pwm_hi == '0 && pwm_lo == '0, "R12", "pins in reset", {pwm_hi, pwm_lo}, 0);
        chk(sync_o == 1'b0, "R12", "sync in reset", sync_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm_hi == '0 && pwm_lo == '0 && !sync_o, "R12", "after reset", {sync_o, pwm_hi, pwm_lo}, 0);
        en = 1'b1;

        // R10: zero period after reset
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(sync_o == 1'b1, "R10", "sync each cycle", sync_o, 1);
            chk(pwm_hi == '0 && pwm_lo == '0, "R10", "pins low", {pwm_hi, pwm_lo}, 0);
        end

        // R2 R3 R4 R5 R6: sweep period, dead time and duty
        for (int pi = 0; pi < 6; pi++) begin
            for (int ti = 0; ti < 4; ti++) begin
                for (int dv = -(plist[pi] + 2); dv <= plist[pi] + 2; dv++) begin
                    apply(plist[pi], tlist[ti], 0, dv, -dv, dv / 2);
                    measure(1'b0, 0, 0);
                    verify(plist[pi], tlist[ti], 0, dv, -dv, dv / 2, "sweep");
                end
            end
        end

        // R8: crossover on channels 0 and 2
        for (int dv = -4; dv <= 4; dv++) begin
            apply(7, 1, 3'b101, dv, -dv, dv / 2);
            measure(1'b0, 0, 0);
            verify(7, 1, 3'b101, dv, -dv, dv / 2, "crossover");
        end

        // R11: unused addresses change nothing
        apply(6, 1, 0, 2, -1, 0);
        wr(6, 16'hFFFF);
        wr(7, 16'hFFFF);
        wait_sync();
        wait_sync();
        measure(1'b0, 0, 0);
        verify(6, 1, 0, 2, -1, 0, "R11 unused address");

        // R7: mid-period duty write waits one boundary
        apply(5, 0, 0, 1, 0, 0);
        measure(1'b1, 3, 2);
        verify(5, 0, 0, 1, 0, 0, "R7 old period");
        measure(1'b0, 0, 0);
        verify(5, 0, 0, 2, 0, 0, "R7 next period");

        // R9: disable, write while off, re-enable
        apply(6, 0, 0, 2, 0, 0);
        repeat (3) @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(pwm_hi == '0 && pwm_lo == '0 && !sync_o, "R9", "disabled silent",
                {sync_o, pwm_hi, pwm_lo}, 0);
        end
        wr(3, -1);
        wr(0, 4);
        @(negedge clk);
        en = 1'b1;
        measure(1'b0, 0, 0);
        chk(m_len == 8, "R9", "first period after enable", m_len, 8);
        verify(4, 0, 0, -1, 0, 0, "R9 restart");

        // R1: large period
        apply(16'h1000, 16'h10, 0, 16'h400, -16'h400, 0);
        measure(1'b0, 0, 0);
        verify(16'h1000, 16'h10, 0, 16'h400, -16'h400, 0, "R1 large period");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule